// File: doc/BRIEF.md
# Fault Shutdown and Clear Controller

This block collects the fault sources of a six-output, three-phase half-bridge gate controller and decides when the gate commands must be forced off. It takes four kinds of input. The first is a synchronous over-current comparator flag, which must stay high for a programmable blanking window before it counts as a fault. The second is a low-side supply under-voltage flag, which trips at once. The third is one high-side supply under-voltage flag per phase. The fourth is an enable that has already been filtered.

A tripped fault holds the active-low fault indication. It also drives a global kill and requests a soft turn-off of the low-side legs. A clock-cycle counter sets a minimum hold time. Release needs both the trip source to be gone and the counter to have run out. If the source is still present when the counter runs out, the counter reloads and the fault stays.

A high-side supply under-voltage kills only its own phase's high-side output and is not reported as a fault. Enable low kills every output at once without reporting a fault. The integrating logic ANDs each gate command with the inverse of the kill outputs.

Top module: `gate_fault_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `fault_n` is 0 and `kill_all`, `ls_soft_off` and every `hs_kill` bit are 1. With no trip source, `fault_n` returns to 1 at the (CLEAR_CYC+1)th rising edge after reset is removed.
- R2: `oc_flag` trips a fault only when it is sampled high at BLANK_CYC+1 consecutive rising edges. Shorter pulses, or runs broken by a single low sample, leave `fault_n` at 1.
- R3: `ls_uv` sampled high at any rising edge trips the fault at that edge, with no blanking.
- R4: A trip loads the clear timer with CLEAR_CYC. The timer counts down by one per edge. The fault clears at the first edge where the timer is zero and no trip source is present, so a fault lasts at least CLEAR_CYC+1 cycles.
- R5: If a trip source is present at an edge where the timer is zero, the timer reloads and the fault continues. A source held for w edges therefore gives a fault lasting a whole multiple of CLEAR_CYC+1 cycles.
- R6: While the fault is held, `kill_all`=1, `ls_soft_off`=1, `hs_kill` is all ones and `fault_n`=0. When it is released, all four return to their normal-operation values.
- R7: `en_filt`=0 forces `kill_all`=1 and every `hs_kill` bit to 1 in the same cycle (combinational path). `fault_n` stays 1 and `ls_soft_off` stays 0.
- R8: `hs_uv[i]`=1 forces `hs_kill[i]`=1 combinationally. Bit i of `hs_uv` maps to bit i of `hs_kill`. It does not change any other `hs_kill` bit, `kill_all` or `fault_n`.
- R9: With no fault held, `en_filt`=1 and `hs_uv`=0, `kill_all`, `ls_soft_off` and `hs_kill` are all 0 and `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| oc_flag | input | 1 | Over-current comparator output, synchronous |
| ls_uv | input | 1 | Low-side supply under-voltage flag |
| hs_uv | input | N_PHASE | High-side supply under-voltage flag per phase |
| en_filt | input | 1 | Filtered enable, 1 = run |
| fault_n | output | 1 | Fault indication, active low |
| kill_all | output | 1 | Forces all gate commands off |
| ls_soft_off | output | 1 | Soft turn-off request for the low-side legs |
| hs_kill | output | N_PHASE | Per-phase high-side kill |

## Verification
The embedded assertions check the following on every cycle:
- a sampled trip always sets the fault on the next edge;
- the fault never drops while the timer is non-zero;
- a release only follows a zero timer with no trip present;
- a zero-timer trip reloads the timer;
- an accepted over-current was already high on the previous edge;
- a high-side under-voltage alone never raises the fault.

Only the bench scenarios can show the exact durations. These are the blanking threshold across a sweep of pulse widths, and the hold length as a multiple of CLEAR_CYC+1 across sweeps of over-current and under-voltage widths. The scenarios also cover the power-up release cycle and the per-phase isolation of the high-side kills.

// File: rtl/gfc_pkg.sv
`timescale 1ns/1ps
package gfc_pkg;
   typedef enum logic {
      FS_RUN  = 1'b0,
      FS_HOLD = 1'b1
   } fault_st_t;

   // Bits needed to hold the value n (at least one).
   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/oc_blanker.sv
`timescale 1ns/1ps
module oc_blanker #(
   parameter int BLANK_CYC = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic oc_raw,
   output logic oc_ok
);
   generate
      if (BLANK_CYC < 0) begin : g_bad_blank
         $error("oc_blanker: BLANK_CYC must be non-negative");
      end

      if (BLANK_CYC == 0) begin : g_no_blank
         assign oc_ok = oc_raw;
      end else begin : g_blank
         localparam int BW = gfc_pkg::cnt_bits(BLANK_CYC);
         localparam logic [BW-1:0] LIMIT = BW'(BLANK_CYC);
         logic [BW-1:0] run_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               run_q <= '0;
            end else if (!oc_raw) begin
               run_q <= '0;
            end else if (run_q != LIMIT) begin
               run_q <= run_q + 1'b1;
            end
         end

         assign oc_ok = oc_raw && (run_q == LIMIT);

         // R2: an accepted over-current was already high one edge earlier
         a_r2_blank_history: assert property (@(posedge clk) disable iff (rst)
            oc_ok |-> $past(oc_raw));
      end
   endgenerate
endmodule

// File: rtl/fault_fsm.sv
`timescale 1ns/1ps
module fault_fsm #(
   parameter int CLEAR_CYC = 162500
) (
   input  logic clk,
   input  logic rst,
   input  logic trig,
   output logic hold
);
   import gfc_pkg::*;

   localparam int TW = cnt_bits(CLEAR_CYC);
   localparam logic [TW-1:0] RELOAD = TW'(CLEAR_CYC);

   generate
      if (CLEAR_CYC < 1) begin : g_bad_clear
         $error("fault_fsm: CLEAR_CYC must be at least 1");
      end
   endgenerate

   fault_st_t     st_q;
   logic [TW-1:0] tmr_q;
   logic          tmr_done;

   assign tmr_done = (tmr_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= FS_HOLD;
         tmr_q <= RELOAD;
      end else begin
         case (st_q)
            FS_RUN: begin
               if (trig) begin
                  st_q  <= FS_HOLD;
                  tmr_q <= RELOAD;
               end
            end
            FS_HOLD: begin
               if (!tmr_done) begin
                  tmr_q <= tmr_q - 1'b1;
               end else if (trig) begin
                  tmr_q <= RELOAD;
               end else begin
                  st_q <= FS_RUN;
               end
            end
            default: st_q <= FS_HOLD;
         endcase
      end
   end

   assign hold = (st_q == FS_HOLD);

   // R3: any sampled trip leaves the fault held after the edge
   a_r3_trip_sets: assert property (@(posedge clk) disable iff (rst)
      trig |=> hold);
   // R4: the fault never drops while the timer is still running
   a_r4_min_hold: assert property (@(posedge clk) disable iff (rst)
      (hold && !tmr_done) |=> hold);
   // R4: a release only follows an expired timer with no trip present
   a_r4_release: assert property (@(posedge clk) disable iff (rst)
      $fell(hold) |-> ($past(tmr_q) == '0 && !$past(trig)));
   // R5: a trip at expiry reloads the timer
   a_r5_rearm: assert property (@(posedge clk) disable iff (rst)
      (hold && tmr_done && trig) |=> (hold && tmr_q == RELOAD));
endmodule

// File: rtl/hs_leg_gate.sv
`timescale 1ns/1ps
module hs_leg_gate (
   input  logic kill_in,
   input  logic leg_uv,
   output logic leg_kill
);
   assign leg_kill = kill_in | leg_uv;
endmodule

// File: rtl/gate_fault_ctrl.sv
`timescale 1ns/1ps
module gate_fault_ctrl #(
   parameter int N_PHASE   = 3,
   parameter int BLANK_CYC = 32,
   parameter int CLEAR_CYC = 162500
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               oc_flag,
   input  logic               ls_uv,
   input  logic [N_PHASE-1:0] hs_uv,
   input  logic               en_filt,
   output logic               fault_n,
   output logic               kill_all,
   output logic               ls_soft_off,
   output logic [N_PHASE-1:0] hs_kill
);
   generate
      if (N_PHASE < 1) begin : g_bad_phase
         $error("gate_fault_ctrl: N_PHASE must be at least 1");
      end
   endgenerate

   logic oc_ok;
   logic trig;
   logic hold;

   oc_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk   (clk),
      .rst   (rst),
      .oc_raw(oc_flag),
      .oc_ok (oc_ok)
   );

   assign trig = oc_ok | ls_uv;

   fault_fsm #(.CLEAR_CYC(CLEAR_CYC)) u_fsm (
      .clk (clk),
      .rst (rst),
      .trig(trig),
      .hold(hold)
   );

   assign fault_n     = ~hold;
   assign ls_soft_off = hold;
   assign kill_all    = hold | ~en_filt;

   generate
      for (genvar p = 0; p < N_PHASE; p++) begin : g_leg
         hs_leg_gate u_leg (
            .kill_in (kill_all),
            .leg_uv  (hs_uv[p]),
            .leg_kill(hs_kill[p])
         );
      end
   endgenerate

   // R2: an accepted over-current always shows on the fault pin next cycle
   a_r2_oc_trip: assert property (@(posedge clk) disable iff (rst)
      oc_ok |=> !fault_n);
   // R8: with no accepted trip, the high-side flags cannot raise the fault
   a_r8_hs_no_fault: assert property (@(posedge clk) disable iff (rst)
      (fault_n && !oc_ok && !ls_uv) |=> fault_n);
endmodule

// File: tb/tb_gate_fault_ctrl.sv
`timescale 1ns/1ps
module tb_gate_fault_ctrl;
   localparam int NP = 3;
   localparam int B  = 4;
   localparam int C  = 10;
   localparam int WIN = 80;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          oc_flag = 1'b0;
   logic          ls_uv = 1'b0;
   logic [NP-1:0] hs_uv = '0;
   logic          en_filt = 1'b1;
   logic          fault_n;
   logic          kill_all;
   logic          ls_soft_off;
   logic [NP-1:0] hs_kill;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   gate_fault_ctrl #(.N_PHASE(NP), .BLANK_CYC(B), .CLEAR_CYC(C)) dut (
      .clk(clk), .rst(rst), .oc_flag(oc_flag), .ls_uv(ls_uv),
      .hs_uv(hs_uv), .en_filt(en_filt), .fault_n(fault_n),
      .kill_all(kill_all), .ls_soft_off(ls_soft_off), .hs_kill(hs_kill)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R6/R9: outputs must all agree with the fault pin
   task automatic check_follow(input string req);
      int exp_k;
      exp_k = fault_n ? 0 : 1;
      check({req, " kill_all"}, int'(kill_all), exp_k);
      check({req, " ls_soft_off"}, int'(ls_soft_off), exp_k);
      check({req, " hs_kill"}, int'(hs_kill), exp_k ? ((1 << NP) - 1) : 0);
   endtask

   // Drive one source high for w edges; return number of low fault samples.
   task automatic pulse(input bit use_oc, input int w, output int lows);
      lows = 0;
      for (int i = 0; i < WIN; i++) begin
         @(negedge clk);
         if (i > 0) begin
            if (!fault_n) lows++;
            check_follow("R6");
         end
         if (use_oc) oc_flag = (i < w);
         else        ls_uv   = (i < w);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int lows;
      int expv;
      // R1: reset state and power-up release timing
      repeat (3) @(negedge clk);
      check("R1 fault_n in reset", int'(fault_n), 0);
      check("R1 kill_all in reset", int'(kill_all), 1);
      check("R1 ls_soft_off in reset", int'(ls_soft_off), 1);
      check("R1 hs_kill in reset", int'(hs_kill), 7);
      rst = 1'b0;
      for (int j = 1; j <= C + 3; j++) begin
         @(negedge clk);
         check("R1 release edge", int'(fault_n), (j > C) ? 1 : 0);
      end
      // R9: quiet running state
      check("R9 kill_all", int'(kill_all), 0);
      check("R9 ls_soft_off", int'(ls_soft_off), 0);
      check("R9 hs_kill", int'(hs_kill), 0);

      // R2/R4/R5: over-current width sweep
      for (int w = 1; w <= 30; w++) begin
         pulse(1'b1, w, lows);
         expv = (w > B) ? (1 + (w - 1 - B) / (C + 1)) * (C + 1) : 0;
         check($sformatf("R2 R5 oc width %0d hold cycles", w), lows, expv);
         check("R4 released after window", int'(fault_n), 1);
      end

      // R3/R4/R5: low-side under-voltage width sweep
      for (int w = 1; w <= 25; w++) begin
         pulse(1'b0, w, lows);
         expv = (1 + (w - 1) / (C + 1)) * (C + 1);
         check($sformatf("R3 R5 uv width %0d hold cycles", w), lows, expv);
         check("R4 released after window", int'(fault_n), 1);
      end

      // R2: runs broken by one low sample never trip
      lows = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!fault_n) lows++;
         oc_flag = (i < 3 * (B + 1)) && ((i % (B + 1)) != B);
      end
      check("R2 interrupted runs", lows, 0);

      // R7: enable low kills everything without a fault
      @(negedge clk);
      en_filt = 1'b0;
      #1;
      check("R7 kill_all", int'(kill_all), 1);
      check("R7 hs_kill", int'(hs_kill), 7);
      check("R7 ls_soft_off", int'(ls_soft_off), 0);
      repeat (3) @(negedge clk);
      check("R7 fault_n", int'(fault_n), 1);
      en_filt = 1'b1;
      #1;
      check("R7 kill_all restored", int'(kill_all), 0);

      // R8: per-phase high-side under-voltage sweep
      for (int p = 0; p < (1 << NP); p++) begin
         @(negedge clk);
         hs_uv = NP'(p);
         #1;
         check("R8 hs_kill follows own phase", int'(hs_kill), p);
         check("R8 kill_all", int'(kill_all), 0);
         @(negedge clk);
         check("R8 fault_n", int'(fault_n), 1);
         check("R8 ls_soft_off", int'(ls_soft_off), 0);
      end
      hs_uv = '0;
      @(negedge clk);
      check("R9 hs_kill clear", int'(hs_kill), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule